// File: doc/BRIEF.md
# Three-Bank GPIO Controller with Pin Interrupts

This block owns ninety general-purpose pins, grouped as three banks of thirty. Software reaches it over a simple 32-bit register bus. For every pin it holds a direction, an alternate-function select, a GPIO-mode enable, interrupt trigger configuration, a sticky interrupt flag, the output value and a two-bit pull setting. It drives the pad output value, the output enable, the select line and the pull code. Pad inputs cross into the clock domain through a two-stage synchronizer. The synchronized level is both readable and fed to a per-pin trigger detector.

Each pin can trigger on a high level, a low level, a rising edge or a falling edge. A trigger sets the pin's status flag, and software clears the flag by writing zero to it. Each bank raises one interrupt line while any input pin has both its status flag and its interrupt enable set.

Registers are grouped by kind in 16-byte groups. Inside a group, the word at byte offset 4·n belongs to bank n, which lets one bus access touch the same register of one bank.

Top module: `multi_bank_gpio`

## Requirements
- R1: Reset is synchronous and active high. During and after reset, every per-bank register reads 0, except direction, which reads 0x3FFFFFFF (all pins inputs). All pad outputs are 0, including output enables, select lines and pull codes. All bank interrupt lines are 0.
- R2: A read is combinational while bus_en=1 and bus_we=0, and a write takes effect at the clock edge where bus_en=1 and bus_we=1. The register group for each kind sits at these offsets: 0x00 direction, 0x10 select, 0x20 polarity, 0x30 type, 0x40 interrupt enable, 0x50 status, 0x60 GPIO enable, 0x70 input data (read-only), 0x80 output data. Bank n uses group offset + 4·n, and address bits 1:0 are ignored. Only bits 29:0 are stored, and bits 31:30 read 0. Offsets in the group at 0x90, word index 3 of any group, and pull words past the last one all read 0, and writing them changes nothing.
- R3: A direction bit of 1 makes the pin an input. pad_oe is the GPIO-enable bit AND NOT the direction bit. pad_out follows the output-data bit and pad_func_sel follows the select bit. Global pin g = 30·bank + pin maps to bit g of each pad vector.
- R4: An input-data read returns the pad level through two flops. A change applied before clock edge k is not visible after edge k, and is visible after edge k+1.
- R5: When the type bit is 0 (level trigger), polarity 1 sets status while the synchronized pin is high, and polarity 0 sets it while the pin is low. The bit is set again on every cycle while the level holds, so writing 0 to clear it has no lasting effect until the level goes away.
- R6: When the type bit is 1 (edge trigger), polarity 1 sets status on a rising edge of the synchronized pin and polarity 0 sets it on a falling edge. The opposite edge does not set it.
- R7: bank_irq[n] is 1 exactly when some bit of (direction AND status AND enable) in bank n is 1. A pin configured as an output still records status but cannot raise the line.
- R8: Writing the status word clears each bit written as 0 and leaves each bit written as 1 unchanged. A trigger in the same cycle wins over a clear. Without a write, set bits stay set.
- R9: Pull words sit at 0xA0 + 4·k for k = 0..5. Pin g owns bits 2·(g mod 16)+1 : 2·(g mod 16) of word g/16, and that field drives pad_pull[2g+1:2g]. A write replaces the whole word. Bits past pin 89 are not stored and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when not reading |
| pad_in | input | 90 | Asynchronous pad levels, bit g = global pin g |
| pad_out | output | 90 | Pad output values |
| pad_oe | output | 90 | Pad output enables |
| pad_func_sel | output | 90 | Alternate-function select per pin |
| pad_pull | output | 180 | Two-bit pull code per pin |
| bank_irq | output | 3 | Combined interrupt line per bank |

## Verification
The hardest situation to create from the ports is a status flag that is set on a pin whose interrupt cannot fire, or whose flag refuses to clear. Examples are an edge caught on a pin configured as an output, a level trigger that re-arms against a clearing write, and an edge of the wrong direction that must leave the flag alone. To reach these, the stimulus first moves every pin of a bank to edge mode and clears stale flags, because after reset the pads idle low and would otherwise hold every level-low flag. It then toggles single pads with enough cycles between steps for the two-flop synchronizer and the detector register. The status word, the input word and the interrupt lines are read back after each step.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    parameter int unsigned BANK_PINS  = 30;
    parameter int unsigned BANK_COUNT = 3;
    parameter int unsigned BUS_DW     = 32;
    parameter int unsigned BUS_AW     = 8;
    parameter int unsigned PULL_BITS  = 2;
    parameter int unsigned GRP_LSB    = 4;
    parameter int unsigned WORD_LSB   = 2;
    parameter int unsigned PIDX_W     = 3;

    localparam int unsigned TOTAL_PINS      = BANK_COUNT * BANK_PINS;
    localparam int unsigned FIELDS_PER_WORD = BUS_DW / PULL_BITS;
    localparam int unsigned PULL_WORDS      = (TOTAL_PINS + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD;
    localparam int unsigned PULL_FLAT       = PULL_WORDS * BUS_DW;
    localparam int unsigned PULL_USED       = TOTAL_PINS * PULL_BITS;

    typedef logic [BANK_PINS-1:0] pinvec_t;

    // Upper address nibble picks the register kind.
    typedef enum logic [3:0] {
        GRP_DIR     = 4'h0,
        GRP_SEL     = 4'h1,
        GRP_POL     = 4'h2,
        GRP_TYP     = 4'h3,
        GRP_IEN     = 4'h4,
        GRP_STS     = 4'h5,
        GRP_GEN     = 4'h6,
        GRP_DIN     = 4'h7,
        GRP_DOUT    = 4'h8,
        GRP_GAP     = 4'h9,
        GRP_PULL_LO = 4'hA,
        GRP_PULL_HI = 4'hB,
        GRP_RSV_C   = 4'hC,
        GRP_RSV_D   = 4'hD,
        GRP_RSV_E   = 4'hE,
        GRP_RSV_F   = 4'hF
    } grp_e;

    typedef struct packed {
        pinvec_t dir;
        pinvec_t sel;
        pinvec_t pol;
        pinvec_t typ;
        pinvec_t ien;
        pinvec_t sts;
        pinvec_t gen;
        pinvec_t dout;
    } bank_cfg_t;

    // Per-pin trigger: type 0 = level, 1 = edge; polarity 1 = high/rising.
    function automatic pinvec_t trig_hits(pinvec_t cur, pinvec_t prev,
                                          pinvec_t pol, pinvec_t typ);
        pinvec_t rise;
        pinvec_t fall;
        pinvec_t lvl;
        pinvec_t edg;
        rise = cur & ~prev;
        fall = ~cur & prev;
        lvl  = (cur & pol) | (~cur & ~pol);
        edg  = (rise & pol) | (fall & ~pol);
        return (typ & edg) | (~typ & lvl);
    endfunction

    function automatic pinvec_t field_pick(bank_cfg_t c, pinvec_t din, grp_e g);
        case (g)
            GRP_DIR:  return c.dir;
            GRP_SEL:  return c.sel;
            GRP_POL:  return c.pol;
            GRP_TYP:  return c.typ;
            GRP_IEN:  return c.ien;
            GRP_STS:  return c.sts;
            GRP_GEN:  return c.gen;
            GRP_DIN:  return din;
            GRP_DOUT: return c.dout;
            default:  return '0;
        endcase
    endfunction

    // Bits of pull word w that belong to an existing pin.
    function automatic logic [BUS_DW-1:0] pull_mask(int unsigned w);
        logic [BUS_DW-1:0] m;
        for (int unsigned b = 0; b < BUS_DW; b++) begin
            m[b] = ((w * BUS_DW) + b) < PULL_USED;
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank import gpio_pkg::*; (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  grp_e      wr_grp,
    input  pinvec_t   wdata,
    input  pinvec_t   pin_sync,
    output bank_cfg_t cfg,
    output logic      irq
);
    bank_cfg_t cfg_q;
    pinvec_t   prev_q;
    pinvec_t   hits;
    pinvec_t   sts_kept;

    assign hits     = trig_hits(pin_sync, prev_q, cfg_q.pol, cfg_q.typ);
    assign sts_kept = (wr_en && (wr_grp == GRP_STS)) ? (cfg_q.sts & wdata) : cfg_q.sts;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            cfg_q.dir <= '1;
            prev_q    <= '0;
        end else begin
            prev_q <= pin_sync;
            if (wr_en) begin
                case (wr_grp)
                    GRP_DIR:  cfg_q.dir  <= wdata;
                    GRP_SEL:  cfg_q.sel  <= wdata;
                    GRP_POL:  cfg_q.pol  <= wdata;
                    GRP_TYP:  cfg_q.typ  <= wdata;
                    GRP_IEN:  cfg_q.ien  <= wdata;
                    GRP_GEN:  cfg_q.gen  <= wdata;
                    GRP_DOUT: cfg_q.dout <= wdata;
                    default:  ;
                endcase
            end
            // A trigger in the same cycle beats a clearing write.
            cfg_q.sts <= sts_kept | hits;
        end
    end

    assign cfg = cfg_q;
    assign irq = |(cfg_q.dir & cfg_q.sts & cfg_q.ien);
endmodule

// File: rtl/gpio_pull_regs.sv
module gpio_pull_regs import gpio_pkg::*; (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [PIDX_W-1:0]    idx,
    input  logic [BUS_DW-1:0]    wdata,
    output logic [BUS_DW-1:0]    rd_data,
    output logic [PULL_USED-1:0] pull
);
    logic [PULL_FLAT-1:0] flat_q;

    for (genvar w = 0; w < PULL_WORDS; w++) begin : g_word
        localparam logic [BUS_DW-1:0] KEEP = pull_mask(w);
        always_ff @(posedge clk) begin
            if (rst) begin
                flat_q[w*BUS_DW +: BUS_DW] <= '0;
            end else if (wr_en && (32'(idx) == w)) begin
                flat_q[w*BUS_DW +: BUS_DW] <= wdata & KEEP;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int unsigned w = 0; w < PULL_WORDS; w++) begin
            if (32'(idx) == w) begin
                rd_data = flat_q[w*BUS_DW +: BUS_DW];
            end
        end
    end

    assign pull = flat_q[PULL_USED-1:0];
endmodule

// File: rtl/multi_bank_gpio.sv
module multi_bank_gpio import gpio_pkg::*; (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_en,
    input  logic                  bus_we,
    input  logic [BUS_AW-1:0]     bus_addr,
    input  logic [BUS_DW-1:0]     bus_wdata,
    output logic [BUS_DW-1:0]     bus_rdata,
    input  logic [TOTAL_PINS-1:0] pad_in,
    output logic [TOTAL_PINS-1:0] pad_out,
    output logic [TOTAL_PINS-1:0] pad_oe,
    output logic [TOTAL_PINS-1:0] pad_func_sel,
    output logic [PULL_USED-1:0]  pad_pull,
    output logic [BANK_COUNT-1:0] bank_irq
);
    grp_e                  grp;
    int unsigned           widx;
    logic [PIDX_W-1:0]     pidx;
    logic                  wr;
    logic                  pull_hit;
    logic                  pull_ok;
    logic [BUS_DW-1:0]     pull_rd;
    logic                  unused_addr_lsb;

    logic [TOTAL_PINS-1:0] din_all;
    logic [TOTAL_PINS-1:0] dir_all;
    logic [TOTAL_PINS-1:0] sts_all;
    logic [TOTAL_PINS-1:0] ien_all;
    logic [TOTAL_PINS-1:0] typ_all;
    logic [TOTAL_PINS-1:0] pol_all;
    logic [BANK_COUNT-1:0] sts_wr;
    bank_cfg_t             cfg [BANK_COUNT];

    assign grp      = grp_e'(bus_addr[BUS_AW-1:GRP_LSB]);
    assign widx     = 32'(bus_addr[GRP_LSB-1:WORD_LSB]);
    assign pidx     = bus_addr[GRP_LSB+PIDX_W-WORD_LSB-1:WORD_LSB];
    assign wr       = bus_en && bus_we;
    assign pull_hit = (grp == GRP_PULL_LO) || (grp == GRP_PULL_HI);
    assign pull_ok  = pull_hit && (32'(pidx) < PULL_WORDS);
    assign unused_addr_lsb = ^bus_addr[WORD_LSB-1:0];

    gpio_sync #(.W(TOTAL_PINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (din_all)
    );

    for (genvar b = 0; b < BANK_COUNT; b++) begin : g_bank
        localparam int unsigned LO = b * BANK_PINS;
        logic bank_wr;
        assign bank_wr = wr && (widx == b) && (grp <= GRP_DOUT);

        gpio_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (bank_wr),
            .wr_grp   (grp),
            .wdata    (bus_wdata[BANK_PINS-1:0]),
            .pin_sync (din_all[LO +: BANK_PINS]),
            .cfg      (cfg[b]),
            .irq      (bank_irq[b])
        );

        assign sts_wr[b]                     = bank_wr && (grp == GRP_STS);
        assign dir_all[LO +: BANK_PINS]      = cfg[b].dir;
        assign sts_all[LO +: BANK_PINS]      = cfg[b].sts;
        assign ien_all[LO +: BANK_PINS]      = cfg[b].ien;
        assign typ_all[LO +: BANK_PINS]      = cfg[b].typ;
        assign pol_all[LO +: BANK_PINS]      = cfg[b].pol;
        assign pad_out[LO +: BANK_PINS]      = cfg[b].dout;
        assign pad_oe[LO +: BANK_PINS]       = cfg[b].gen & ~cfg[b].dir;
        assign pad_func_sel[LO +: BANK_PINS] = cfg[b].sel;
    end

    gpio_pull_regs u_pull (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr && pull_ok),
        .idx     (pidx),
        .wdata   (bus_wdata),
        .rd_data (pull_rd),
        .pull    (pad_pull)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            if (pull_ok) begin
                bus_rdata = pull_rd;
            end else if (grp <= GRP_DOUT) begin
                for (int unsigned b = 0; b < BANK_COUNT; b++) begin
                    if (widx == b) begin
                        bus_rdata = BUS_DW'(field_pick(cfg[b],
                                        din_all[b*BANK_PINS +: BANK_PINS], grp));
                    end
                end
            end
        end
    end
endmodule

// File: rtl/gpio_chk.sv
module gpio_chk import gpio_pkg::*; (
    input logic                  clk,
    input logic                  rst,
    input logic [BUS_AW-1:0]     bus_addr,
    input logic [BUS_DW-1:0]     bus_rdata,
    input logic [TOTAL_PINS-1:0] pad_oe,
    input logic [TOTAL_PINS-1:0] dir_all,
    input logic [TOTAL_PINS-1:0] sts_all,
    input logic [TOTAL_PINS-1:0] ien_all,
    input logic [TOTAL_PINS-1:0] typ_all,
    input logic [TOTAL_PINS-1:0] pol_all,
    input logic [TOTAL_PINS-1:0] din_all,
    input logic [BANK_COUNT-1:0] sts_wr,
    input logic [BANK_COUNT-1:0] bank_irq
);
    AST_RESET_ALL_INPUTS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dir_all == '1)); // R1

    AST_OE_ONLY_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe & dir_all) == '0)); // R3

    AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[BUS_AW-1:GRP_LSB] < 4'hA) |-> (bus_rdata[BUS_DW-1:BANK_PINS] == '0)); // R2

    AST_RISE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (($past(din_all) & ~$past(din_all, 2) & $past(typ_all & pol_all) & ~sts_all) == '0)); // R6

    for (genvar b = 0; b < BANK_COUNT; b++) begin : g_bank_chk
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
            !sts_wr[b] |=> (($past(sts_all[b*BANK_PINS +: BANK_PINS])
                             & ~sts_all[b*BANK_PINS +: BANK_PINS]) == '0)); // R8

        AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
            (ien_all[b*BANK_PINS +: BANK_PINS] == '0) |-> !bank_irq[b]); // R7
    end
endmodule

bind multi_bank_gpio gpio_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .dir_all   (dir_all),
    .sts_all   (sts_all),
    .ien_all   (ien_all),
    .typ_all   (typ_all),
    .pol_all   (pol_all),
    .din_all   (din_all),
    .sts_wr    (sts_wr),
    .bank_irq  (bank_irq)
);

// File: tb/tb_multi_bank_gpio.sv
module tb_multi_bank_gpio;
    import gpio_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int SRC_RD     = 0;
    localparam int SRC_IRQ    = 1;
    localparam int SRC_OE     = 2;
    localparam int SRC_OUT    = 3;
    localparam int SRC_SEL    = 4;
    localparam int SRC_PULLW  = 5;
    localparam int SRC_PULLF  = 6;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  bus_en = 1'b0;
    logic                  bus_we = 1'b0;
    logic [BUS_AW-1:0]     bus_addr = '0;
    logic [BUS_DW-1:0]     bus_wdata = '0;
    logic [BUS_DW-1:0]     bus_rdata;
    logic [TOTAL_PINS-1:0] pad_in = '0;
    logic [TOTAL_PINS-1:0] pad_out;
    logic [TOTAL_PINS-1:0] pad_oe;
    logic [TOTAL_PINS-1:0] pad_func_sel;
    logic [PULL_USED-1:0]  pad_pull;
    logic [BANK_COUNT-1:0] bank_irq;
    logic [PULL_FLAT-1:0]  pull_ext;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    typedef struct {
        int          src;
        int          idx;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    event  sample_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign pull_ext = PULL_FLAT'(pad_pull);

    multi_bank_gpio dut (
        .clk          (clk),
        .rst          (rst),
        .bus_en       (bus_en),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .pad_in       (pad_in),
        .pad_out      (pad_out),
        .pad_oe       (pad_oe),
        .pad_func_sel (pad_func_sel),
        .pad_pull     (pad_pull),
        .bank_irq     (bank_irq)
    );

    function automatic logic [31:0] observe(int src, int idx);
        case (src)
            SRC_RD:    return bus_rdata;
            SRC_IRQ:   return 32'(bank_irq);
            SRC_OE:    return 32'(pad_oe[idx*BANK_PINS +: BANK_PINS]);
            SRC_OUT:   return 32'(pad_out[idx*BANK_PINS +: BANK_PINS]);
            SRC_SEL:   return 32'(pad_func_sel[idx*BANK_PINS +: BANK_PINS]);
            SRC_PULLW: return pull_ext[idx*BUS_DW +: BUS_DW];
            SRC_PULLF: return 32'(pad_pull[idx*PULL_BITS +: PULL_BITS]);
            default:   return 32'hDEAD_BEEF;
        endcase
    endfunction

    // Monitor: pops expected items and compares with the observed port.
    always @(sample_ev) begin
        item_t it;
        logic [31:0] act;
        while (q.size() > 0) begin
            it  = q.pop_front();
            act = observe(it.src, it.idx);
            n_checks++;
            if (act !== it.exp) begin
                n_err++;
                $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
            end
        end
    end

    task automatic expect_val(input int src, input int idx, input logic [31:0] addr,
                              input logic [31:0] exp, input string req);
        item_t it;
        @(negedge clk);
        bus_en   = (src == SRC_RD);
        bus_we   = 1'b0;
        bus_addr = addr[BUS_AW-1:0];
        #1;
        it.src = src; it.idx = idx; it.exp = exp; it.req = req;
        q.push_back(it);
        ->sample_ev;
        #1;
    endtask

    task automatic rd(input logic [31:0] addr, input logic [31:0] exp, input string req);
        expect_val(SRC_RD, 0, addr, exp, req);
    endtask

    task automatic wr(input logic [31:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_en    = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = addr[BUS_AW-1:0];
        bus_wdata = data;
        @(negedge clk);
        bus_en = 1'b0;
        bus_we = 1'b0;
    endtask

    task automatic set_pin(input int g, input logic v);
        @(negedge clk);
        pad_in[g] = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: values while reset is held
        idle(3);
        rd(32'h00, 32'h3FFF_FFFF, "R1 dir bank0 reset");
        rd(32'h08, 32'h3FFF_FFFF, "R1 dir bank2 reset");
        rd(32'h80, 32'h0,         "R1 dout reset");
        rd(32'h50, 32'h0,         "R1 status reset");
        expect_val(SRC_IRQ, 0, 0, 32'h0, "R1 irq reset");
        expect_val(SRC_OE,  1, 0, 32'h0, "R1 oe reset");
        expect_val(SRC_PULLW, 0, 0, 32'h0, "R1 pull reset");
        @(negedge clk);
        rst = 1'b0;
        idle(2);
        rd(32'h04, 32'h3FFF_FFFF, "R1 dir after release");

        // R2: layout, masking, holes
        wr(32'h84, 32'hFFFF_FFFF);
        rd(32'h84, 32'h3FFF_FFFF, "R2 dout bank1 masked");
        rd(32'h80, 32'h0,         "R2 dout bank0 untouched");
        rd(32'h88, 32'h0,         "R2 dout bank2 untouched");
        wr(32'h8C, 32'h0000_1234);
        rd(32'h8C, 32'h0, "R2 word index 3 reads zero");
        rd(32'h80, 32'h0, "R2 index 3 write no effect b0");
        rd(32'h88, 32'h0, "R2 index 3 write no effect b2");
        wr(32'h90, 32'hFFFF_FFFF);
        rd(32'h90, 32'h0, "R2 gap group reads zero");
        rd(32'h86, 32'h3FFF_FFFF, "R2 low address bits ignored");

        // R3: direction, enable, select
        wr(32'h64, 32'h3FFF_FFFF);
        wr(32'h04, 32'h0000_FFFF);
        expect_val(SRC_OE,  1, 0, 32'h3FFF_0000, "R3 oe = gen and not dir");
        expect_val(SRC_OE,  0, 0, 32'h0,         "R3 oe bank0 all inputs");
        expect_val(SRC_OUT, 1, 0, 32'h3FFF_FFFF, "R3 pad_out follows dout");
        wr(32'h14, 32'h0000_0005);
        expect_val(SRC_SEL, 1, 0, 32'h5, "R3 select bank1");
        expect_val(SRC_SEL, 0, 0, 32'h0, "R3 select bank0");

        // R4: two-flop input latency
        @(negedge clk);
        pad_in[2*BANK_PINS +: BANK_PINS] = 30'h15;
        rd(32'h78, 32'h0,  "R4 not visible after one edge");
        rd(32'h78, 32'h15, "R4 visible after two edges");

        // R5: level triggers on bank0 pin3
        wr(32'h30, 32'h3FFF_FFFF);
        wr(32'h50, 32'h0);
        rd(32'h50, 32'h0, "R5 status cleared in edge mode");
        wr(32'h20, 32'h8);
        wr(32'h30, 32'h3FFF_FFF7);
        wr(32'h40, 32'h8);
        idle(2);
        rd(32'h50, 32'h0, "R5 level high not met");
        expect_val(SRC_IRQ, 0, 0, 32'h0, "R7 no irq before trigger");
        set_pin(3, 1'b1);
        idle(4);
        rd(32'h50, 32'h8, "R5 level high sets status");
        expect_val(SRC_IRQ, 0, 0, 32'h1, "R7 irq bank0 raised");
        wr(32'h50, 32'h0);
        rd(32'h50, 32'h8, "R5 level re-sets against clear");
        set_pin(3, 1'b0);
        idle(4);
        wr(32'h50, 32'h0);
        rd(32'h50, 32'h0, "R5 clear succeeds once level gone");
        expect_val(SRC_IRQ, 0, 0, 32'h0, "R7 irq drops after clear");
        wr(32'h20, 32'h0);
        idle(2);
        rd(32'h50, 32'h8, "R5 level low sets status");
        wr(32'h30, 32'h3FFF_FFFF);
        wr(32'h50, 32'h0);
        rd(32'h50, 32'h0, "R8 clear after edge mode");

        // R6: edges on bank1 pins 5 (rising) and 6 (falling)
        wr(32'h34, 32'h3FFF_FFFF);
        wr(32'h54, 32'h0);
        wr(32'h24, 32'h20);
        rd(32'h54, 32'h0, "R6 bank1 clean start");
        set_pin(BANK_PINS + 5, 1'b1);
        idle(4);
        rd(32'h54, 32'h20, "R6 rising edge sets pin5");
        wr(32'h54, 32'h0);
        set_pin(BANK_PINS + 5, 1'b0);
        idle(4);
        rd(32'h54, 32'h0, "R6 falling edge ignored on rising pin");
        set_pin(BANK_PINS + 6, 1'b1);
        idle(4);
        rd(32'h54, 32'h0, "R6 rising edge ignored on falling pin");
        set_pin(BANK_PINS + 6, 1'b0);
        idle(4);
        rd(32'h54, 32'h40, "R6 falling edge sets pin6");

        // R8: write-one keeps, write-zero clears
        wr(32'h54, 32'hFFFF_FFFF);
        rd(32'h54, 32'h40, "R8 writing ones keeps status");
        wr(32'h54, 32'hFFFF_FFBF);
        rd(32'h54, 32'h0, "R8 writing zero clears bit");

        // R7: output pin records status but does not interrupt
        wr(32'h44, 32'h0010_0020);
        set_pin(BANK_PINS + 20, 1'b1);
        idle(2);
        set_pin(BANK_PINS + 20, 1'b0);
        idle(4);
        rd(32'h54, 32'h0010_0000, "R7 output pin records status");
        expect_val(SRC_IRQ, 0, 0, 32'h0, "R7 output pin masked from irq");
        set_pin(BANK_PINS + 5, 1'b1);
        idle(4);
        expect_val(SRC_IRQ, 0, 0, 32'h2, "R7 input pin raises bank1 irq");

        // R9: pull words
        wr(32'hA4, 32'hFFFF_FFFF);
        rd(32'hA4, 32'hFFFF_FFFF, "R9 pull word1 readback");
        expect_val(SRC_PULLW, 1, 0, 32'hFFFF_FFFF, "R9 pull word1 pads");
        rd(32'hA0, 32'h0, "R9 pull word0 untouched");
        wr(32'hB4, 32'hFFFF_FFFF);
        rd(32'hB4, 32'h000F_FFFF, "R9 last word trimmed");
        wr(32'hB8, 32'hFFFF_FFFF);
        rd(32'hB8, 32'h0, "R9 word past end reads zero");
        wr(32'hA8, 32'h0002_0000);
        expect_val(SRC_PULLF, 40, 0, 32'h2, "R9 pin40 field");
        expect_val(SRC_PULLF, 41, 0, 32'h0, "R9 pin41 field");

        done = 1'b1;
        idle(1);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule